// File: doc/BRIEF.md
# Processor Link Pattern Tester

This block exercises a parallel point-to-point link between two trigger processors that moves one word per 40 MHz bunch crossing. Its transmit half drives a repeating test sequence onto the link: a walking one, a walking zero, or a short table of payload words computed in logic. A start marker goes out with the first word of every sequence. The word width is a parameter, so one build can serve the wide direction (three candidates in 52 bits) and another the narrow direction (one segment in 26 bits).

The receive half takes the far end's word and marker. It first flips each line named in a polarity-correction mask, which covers a connector that was fitted reversed. Checking starts at the first marker. From then on each corrected word is compared against the expected sequence, and the word is also pushed into a small capture FIFO that can be read out later.

The checker reports four things. The first is the error mask of the last word. The second is a sticky mask of every line ever seen wrong. The third is a mask of lines that were wrong on every word, which points to stuck or missing lines. The fourth is a saturating count of bad words. In the walking modes it also records the first case where the single active bit arrives on the wrong line, which points to two swapped lines.

Top module: `lptu_link_test`

## Requirements
- R1: Mode encoding on `pat_mode` is 0 walking one, 1 walking zero, 2 or 3 table. Word k of the walking-one sequence has only bit k set, and word k of the walking-zero sequence has only bit k clear, with k running from 0 to W-1. Table word k, with k running from 0 to TBL_DEPTH-1, has bit b set exactly when (3b+5k) mod 7 < 3. Each sequence repeats from word 0.
- R2: The first word appears on `tx_data` one cycle after `tx_en` is sampled high. `tx_marker` is high together with every word 0. While `tx_en` is low, `tx_data` is zero and `tx_marker` is low.
- R3: While `chk_en` is high, the receiver checks words only from a received marker onward, and a marker restarts the expected sequence at word 0. Words that arrive before the first marker are ignored. Dropping `chk_en` clears `aligned`.
- R4: The received word is XORed with `inv_mask` before it is compared and before it is captured.
- R5: One cycle after a word is checked, `err_mask` holds the XOR of the corrected word and the expected word.
- R6: `sticky_mask` is the OR of the error masks of all words checked since the last clear.
- R7: `stuck_mask` holds the lines that were wrong in every word checked since the last clear. It is zero when no word has been checked.
- R8: In the walking modes, take the corrected word (inverted for walking zero). If it has exactly one bit set and that bit is not the expected one, the first such event since the last clear sets `swap_flag` and records the expected position in `swap_exp` and the received position in `swap_got`.
- R9: `err_count` goes up by one for each checked word with a non-zero error mask and saturates at 2^CW-1.
- R10: `clr` clears `err_mask`, `sticky_mask`, `stuck_mask`, `err_count`, the swap record and `cap_overflow` on the next cycle, and it takes priority over updates in the same cycle.
- R11: Every checked word is written, in its corrected form, into the capture FIFO. Reading is show-ahead: `cap_data` shows the oldest word and `cap_rd` pops it. A read while the FIFO is empty is ignored.
- R12: A write to a full FIFO is dropped and sets `cap_overflow`, which stays high until `clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Active-low reset |
| pat_mode | input | 2 | Pattern selection for both halves |
| tx_en | input | 1 | Run the transmit sequence |
| tx_data | output | W | Transmitted test word |
| tx_marker | output | 1 | Start marker sent with word 0 |
| chk_en | input | 1 | Enable the receive checker |
| inv_mask | input | W | Per-line polarity correction |
| rx_data | input | W | Received word |
| rx_marker | input | 1 | Received start marker |
| clr | input | 1 | Clear results and overflow |
| aligned | output | 1 | Checker has seen a marker |
| err_mask | output | W | Error lines of the last checked word |
| sticky_mask | output | W | Lines ever wrong since clear |
| stuck_mask | output | W | Lines always wrong since clear |
| err_count | output | CW | Saturating count of bad words |
| swap_flag | output | 1 | A swap candidate was recorded |
| swap_exp | output | IW | Expected position of the swap candidate |
| swap_got | output | IW | Received position of the swap candidate |
| cap_rd | input | 1 | Pop the capture FIFO |
| cap_data | output | W | Oldest captured word |
| cap_empty | output | 1 | FIFO empty |
| cap_full | output | 1 | FIFO full |
| cap_overflow | output | 1 | A capture write was dropped |

## Verification
The bench first steps through polarity and fault vectors in every mode. An inversion mask that exactly cancels a line fault must give a clean result. A design that corrected after comparing, or not at all, would count every word as bad.

It then swaps line pairs in both walking modes. A missed swap would leave `swap_flag` low, and a checker that kept the last swap event instead of the first would report the reversed pair. Because swapped lines are wrong only on some words, they must appear in the sticky mask but not in the stuck mask.

Two further cases target alignment and saturation. Words sent with the marker suppressed must leave the count at zero, while a checker that started without a marker would count them. Repeated faulty runs push the counter past its top, where a counter that wrapped would show a small value.

The last cases cover the capture FIFO. Filling it exactly must not raise overflow, a read from an empty FIFO must change nothing, and an overfill must hold the overflow flag until it is cleared.

// File: rtl/lptu_pkg.sv
package lptu_pkg;
    typedef enum logic [1:0] {
        PAT_WALK1  = 2'd0,
        PAT_WALK0  = 2'd1,
        PAT_TABLE  = 2'd2,
        PAT_TABLE2 = 2'd3
    } pat_mode_e;
endpackage

// File: rtl/lptu_pattern.sv
module lptu_pattern #(
    parameter int W  = 26,
    parameter int IW = 5
) (
    input  lptu_pkg::pat_mode_e mode,
    input  logic [IW-1:0]       idx,
    output logic [W-1:0]        word
);
    import lptu_pkg::*;

    always_comb begin
        word = '0;
        for (int b = 0; b < W; b++) begin
            case (mode)
                PAT_WALK1: word[b] = (IW'(b) == idx);
                PAT_WALK0: word[b] = (IW'(b) != idx);
                default:   word[b] = (((3 * b) + (5 * int'(idx))) % 7) < 3;
            endcase
        end
    end
endmodule

// File: rtl/lptu_tx_gen.sv
module lptu_tx_gen #(
    parameter int W         = 26,
    parameter int IW        = 5,
    parameter int TBL_DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  lptu_pkg::pat_mode_e mode,
    input  logic                tx_en,
    output logic [W-1:0]        tx_data,
    output logic                tx_marker
);
    import lptu_pkg::*;

    typedef struct packed {
        logic [IW-1:0] idx;
        logic [W-1:0]  data;
        logic          mark;
    } tx_st_t;

    tx_st_t        st_d, st_q;
    logic [W-1:0]  pat_w;
    logic [IW-1:0] last_idx;

    lptu_pattern #(.W(W), .IW(IW)) u_pat (.mode(mode), .idx(st_q.idx), .word(pat_w));

    always_comb begin
        last_idx = (mode == PAT_WALK1 || mode == PAT_WALK0) ? IW'(W - 1) : IW'(TBL_DEPTH - 1);
        st_d     = st_q;
        if (tx_en) begin
            st_d.data = pat_w;
            st_d.mark = (st_q.idx == '0);
            st_d.idx  = (st_q.idx == last_idx) ? '0 : st_q.idx + 1'b1;
        end else begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_data   = st_q.data;
    assign tx_marker = st_q.mark;

    // R2
    tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (!tx_marker && tx_data == '0));
endmodule

// File: rtl/lptu_rx_check.sv
module lptu_rx_check #(
    parameter int W         = 26,
    parameter int IW        = 5,
    parameter int TBL_DEPTH = 8,
    parameter int CW        = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  lptu_pkg::pat_mode_e mode,
    input  logic                chk_en,
    input  logic                clr,
    input  logic [W-1:0]        inv_mask,
    input  logic [W-1:0]        rx_data,
    input  logic                rx_marker,
    output logic                aligned,
    output logic [W-1:0]        err_mask,
    output logic [W-1:0]        sticky_mask,
    output logic [W-1:0]        stuck_mask,
    output logic [CW-1:0]       err_count,
    output logic                swap_flag,
    output logic [IW-1:0]       swap_exp,
    output logic [IW-1:0]       swap_got,
    output logic                cap_wr,
    output logic [W-1:0]        cap_word
);
    import lptu_pkg::*;

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    typedef struct packed {
        logic [IW-1:0] idx;
        logic          aligned;
        logic [W-1:0]  err;
        logic [W-1:0]  sticky;
        logic [W-1:0]  always_bad;
        logic          seen;
        logic [CW-1:0] cnt;
        logic          swp;
        logic [IW-1:0] sexp;
        logic [IW-1:0] sgot;
    } rx_st_t;

    rx_st_t        st_d, st_q;
    logic [W-1:0]  corr, exp_w, diff, got_v, exp_v;
    logic [IW-1:0] cur_idx, last_idx;
    logic          active, walking;

    function automatic logic [IW-1:0] bit_pos(input logic [W-1:0] v);
        bit_pos = '0;
        for (int b = 0; b < W; b++) if (v[b]) bit_pos = IW'(b);
    endfunction

    lptu_pattern #(.W(W), .IW(IW)) u_pat (.mode(mode), .idx(cur_idx), .word(exp_w));

    always_comb begin
        corr     = rx_data ^ inv_mask;
        active   = chk_en && (rx_marker || st_q.aligned);
        cur_idx  = rx_marker ? '0 : st_q.idx;
        walking  = (mode == PAT_WALK1) || (mode == PAT_WALK0);
        last_idx = walking ? IW'(W - 1) : IW'(TBL_DEPTH - 1);
        diff     = corr ^ exp_w;
        got_v    = (mode == PAT_WALK0) ? ~corr  : corr;
        exp_v    = (mode == PAT_WALK0) ? ~exp_w : exp_w;
        st_d     = st_q;
        if (!chk_en) st_d.aligned = 1'b0;
        if (active) begin
            st_d.aligned    = 1'b1;
            st_d.idx        = (cur_idx == last_idx) ? '0 : cur_idx + 1'b1;
            st_d.err        = diff;
            st_d.sticky     = st_q.sticky | diff;
            st_d.always_bad = st_q.always_bad & diff;
            st_d.seen       = 1'b1;
            if (diff != '0 && st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
            if (walking && !st_q.swp && $countones(got_v) == 1 && got_v != exp_v) begin
                st_d.swp  = 1'b1;
                st_d.sexp = bit_pos(exp_v);
                st_d.sgot = bit_pos(got_v);
            end
        end
        if (clr) begin
            st_d.err        = '0;
            st_d.sticky     = '0;
            st_d.always_bad = '1;
            st_d.seen       = 1'b0;
            st_d.cnt        = '0;
            st_d.swp        = 1'b0;
            st_d.sexp       = '0;
            st_d.sgot       = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.always_bad <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign aligned     = st_q.aligned;
    assign err_mask    = st_q.err;
    assign sticky_mask = st_q.sticky;
    assign stuck_mask  = st_q.seen ? st_q.always_bad : '0;
    assign err_count   = st_q.cnt;
    assign swap_flag   = st_q.swp;
    assign swap_exp    = st_q.sexp;
    assign swap_got    = st_q.sgot;
    assign cap_wr      = active;
    assign cap_word    = corr;

    // R9
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == CNT_MAX && !clr) |=> err_count == CNT_MAX);
    // R10
    clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (err_count == '0 && sticky_mask == '0 && !swap_flag));
    // R7
    stuck_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stuck_mask & ~sticky_mask) == '0);
    // R3
    idle_unaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en |=> !aligned);
endmodule

// File: rtl/lptu_capture_fifo.sv
module lptu_capture_fifo #(
    parameter int W     = 26,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    input  logic         clr,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full,
    output logic         overflow
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_CNT = (AW + 1)'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [AW:0]             cnt;
        logic                    ovf;
    } ff_st_t;

    ff_st_t st_d, st_q;
    logic   do_wr, do_rd;

    always_comb begin
        st_d  = st_q;
        do_wr = wr && (st_q.cnt != FULL_CNT);
        do_rd = rd && (st_q.cnt != '0);
        if (do_wr) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp           = st_q.wp + 1'b1;
        end
        if (wr && !do_wr) st_d.ovf = 1'b1;
        if (do_rd) st_d.rp = st_q.rp + 1'b1;
        st_d.cnt = st_q.cnt + (AW + 1)'(do_wr) - (AW + 1)'(do_rd);
        if (clr) st_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata    = st_q.mem[st_q.rp];
    assign empty    = (st_q.cnt == '0);
    assign full     = (st_q.cnt == FULL_CNT);
    assign overflow = st_q.ovf;

    // R12
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clr) |=> overflow);
    // R12
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr && !rd && !clr) |=> (full && overflow));
    // R11
    empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd && !wr) |=> empty);
endmodule

// File: rtl/lptu_link_test.sv
module lptu_link_test #(
    parameter int W         = 26,
    parameter int TBL_DEPTH = 8,
    parameter int CW        = 8,
    parameter int CAP_DEPTH = 8,
    localparam int MAXLEN   = (W > TBL_DEPTH) ? W : TBL_DEPTH,
    localparam int IW       = $clog2(MAXLEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    pat_mode,
    input  logic          tx_en,
    output logic [W-1:0]  tx_data,
    output logic          tx_marker,
    input  logic          chk_en,
    input  logic [W-1:0]  inv_mask,
    input  logic [W-1:0]  rx_data,
    input  logic          rx_marker,
    input  logic          clr,
    output logic          aligned,
    output logic [W-1:0]  err_mask,
    output logic [W-1:0]  sticky_mask,
    output logic [W-1:0]  stuck_mask,
    output logic [CW-1:0] err_count,
    output logic          swap_flag,
    output logic [IW-1:0] swap_exp,
    output logic [IW-1:0] swap_got,
    input  logic          cap_rd,
    output logic [W-1:0]  cap_data,
    output logic          cap_empty,
    output logic          cap_full,
    output logic          cap_overflow
);
    import lptu_pkg::*;

    pat_mode_e    mode;
    logic         cap_wr;
    logic [W-1:0] cap_word;

    assign mode = pat_mode_e'(pat_mode);

    lptu_tx_gen #(.W(W), .IW(IW), .TBL_DEPTH(TBL_DEPTH)) u_tx (
        .clk(clk), .rst_n(rst_n), .mode(mode), .tx_en(tx_en),
        .tx_data(tx_data), .tx_marker(tx_marker)
    );

    lptu_rx_check #(.W(W), .IW(IW), .TBL_DEPTH(TBL_DEPTH), .CW(CW)) u_rx (
        .clk(clk), .rst_n(rst_n), .mode(mode), .chk_en(chk_en), .clr(clr),
        .inv_mask(inv_mask), .rx_data(rx_data), .rx_marker(rx_marker),
        .aligned(aligned), .err_mask(err_mask), .sticky_mask(sticky_mask),
        .stuck_mask(stuck_mask), .err_count(err_count), .swap_flag(swap_flag),
        .swap_exp(swap_exp), .swap_got(swap_got), .cap_wr(cap_wr), .cap_word(cap_word)
    );

    lptu_capture_fifo #(.W(W), .DEPTH(CAP_DEPTH)) u_cap (
        .clk(clk), .rst_n(rst_n), .wr(cap_wr), .wdata(cap_word), .rd(cap_rd),
        .clr(clr), .rdata(cap_data), .empty(cap_empty), .full(cap_full),
        .overflow(cap_overflow)
    );
endmodule

// File: tb/tb_lptu_link_test.sv
module tb_lptu_link_test;
    localparam int W = 26;
    localparam int TBL = 8;
    localparam int CW = 8;
    localparam int IW = 5;
    localparam int NV = 6;

    localparam logic [1:0]   V_MODE  [NV] = '{2'd0, 2'd1, 2'd2, 2'd0, 2'd2, 2'd1};
    localparam logic [W-1:0] V_FAULT [NV] = '{26'h0, 26'h10, 26'h0, 26'h2000000, 26'hF0, 26'h1};
    localparam logic [W-1:0] V_INV   [NV] = '{26'h0, 26'h0, 26'h3, 26'h2000000, 26'h0F, 26'h1};

    logic clk = 0, rst_n = 0;
    logic [1:0] pat_mode = 0;
    logic tx_en = 0, chk_en = 0, clr = 0, cap_rd = 0;
    logic [W-1:0] inv_mask = 0, fault = 0, tx_data, rx_data, err_mask, sticky_mask, stuck_mask, cap_data;
    logic tx_marker, rx_marker, aligned, swap_flag, cap_empty, cap_full, cap_overflow;
    logic [CW-1:0] err_count;
    logic [IW-1:0] swap_exp, swap_got;
    logic kill_mark = 0, swap_on = 0;
    int sa = 0, sb = 0;
    int errors = 0, checks = 0;
    logic [W-1:0] w;

    always #5 clk = ~clk;

    always_comb begin
        w = tx_data;
        if (swap_on) begin
            w[sa] = tx_data[sb];
            w[sb] = tx_data[sa];
        end
        rx_data = w ^ fault;
    end
    assign rx_marker = tx_marker & ~kill_mark;

    lptu_link_test dut (
        .clk(clk), .rst_n(rst_n), .pat_mode(pat_mode), .tx_en(tx_en),
        .tx_data(tx_data), .tx_marker(tx_marker), .chk_en(chk_en),
        .inv_mask(inv_mask), .rx_data(rx_data), .rx_marker(rx_marker),
        .clr(clr), .aligned(aligned), .err_mask(err_mask),
        .sticky_mask(sticky_mask), .stuck_mask(stuck_mask),
        .err_count(err_count), .swap_flag(swap_flag), .swap_exp(swap_exp),
        .swap_got(swap_got), .cap_rd(cap_rd), .cap_data(cap_data),
        .cap_empty(cap_empty), .cap_full(cap_full), .cap_overflow(cap_overflow)
    );

    function automatic logic [W-1:0] exp_word(input logic [1:0] m, input int k);
        logic [W-1:0] r;
        r = '0;
        if (m == 2'd0) r = 26'b1 << k;
        else if (m == 2'd1) r = ~(26'b1 << k);
        else for (int b = 0; b < W; b++) r[b] = ((3 * b + 5 * k) % 7) < 3;
        return r;
    endfunction

    function automatic int seq_len(input logic [1:0] m);
        return (m < 2) ? W : TBL;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_clr();
        clr = 1;
        @(negedge clk);
        clr = 0;
    endtask

    task automatic run_seq(input logic [1:0] m, input logic [W-1:0] f, input logic [W-1:0] inv, input bit do_clr);
        pat_mode = m;
        fault = f;
        inv_mask = inv;
        if (do_clr) pulse_clr();
        tx_en = 1;
        chk_en = 1;
        repeat (seq_len(m)) @(negedge clk);
        tx_en = 0;
        @(negedge clk);
        chk_en = 0;
        @(negedge clk);
    endtask

    task automatic drain();
        while (!cap_empty) begin
            cap_rd = 1;
            @(negedge clk);
        end
        cap_rd = 0;
    endtask

    bit done = 0;
    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        check("R2 reset marker", tx_marker, 0);
        check("R9 reset count", err_count, 0);
        check("R3 reset aligned", aligned, 0);
        check("R11 reset empty", cap_empty, 1);
        check("R7 reset stuck", stuck_mask, 0);

        // R1 / R2 transmit timing
        pat_mode = 2'd0;
        tx_en = 1;
        @(negedge clk);
        check("R2 first word", tx_data, exp_word(2'd0, 0));
        check("R2 marker with word 0", tx_marker, 1);
        @(negedge clk);
        check("R1 walking one word 1", tx_data, exp_word(2'd0, 1));
        check("R2 marker only on word 0", tx_marker, 0);
        tx_en = 0;
        @(negedge clk);
        check("R2 idle data", tx_data, 0);

        // vector table: R1 R4 R5 R6 R7 R9
        for (int v = 0; v < NV; v++) begin
            logic [W-1:0] d;
            d = V_FAULT[v] ^ V_INV[v];
            run_seq(V_MODE[v], V_FAULT[v], V_INV[v], 1);
            check("R5 R4 last error mask", err_mask, d);
            check("R6 sticky mask", sticky_mask, d);
            check("R7 stuck mask", stuck_mask, d);
            check("R9 R1 error count", err_count, (d != 0) ? seq_len(V_MODE[v]) : 0);
        end

        // R3 no marker: nothing checked
        kill_mark = 1;
        run_seq(2'd0, 26'h4, 0, 1);
        kill_mark = 0;
        check("R3 unaligned count", err_count, 0);
        check("R3 unaligned flag", aligned, 0);
        check("R7 no words stuck zero", stuck_mask, 0);

        // R8 swapped lines, walking one
        swap_on = 1; sa = 2; sb = 5;
        run_seq(2'd0, 0, 0, 1);
        check("R8 swap flag w1", swap_flag, 1);
        check("R8 swap expected w1", swap_exp, 2);
        check("R8 swap got w1", swap_got, 5);
        check("R6 swap sticky", sticky_mask, 26'h24);
        check("R7 swap not stuck", stuck_mask, 0);
        // R8 walking zero
        sa = 7; sb = 9;
        run_seq(2'd1, 0, 0, 1);
        check("R8 swap expected w0", swap_exp, 7);
        check("R8 swap got w0", swap_got, 9);
        swap_on = 0;

        // R9 saturation
        run_seq(2'd0, 26'h1, 0, 1);
        for (int i = 0; i < 9; i++) run_seq(2'd0, 26'h1, 0, 0);
        check("R9 saturated count", err_count, 255);
        // R10 clear
        pulse_clr();
        check("R10 count cleared", err_count, 0);
        check("R10 sticky cleared", sticky_mask, 0);
        check("R10 overflow cleared", cap_overflow, 0);

        // R11 capture contents
        drain();
        run_seq(2'd2, 26'h3, 26'h3, 1);
        check("R11 full after 8", cap_full, 1);
        check("R12 no overflow at exact fill", cap_overflow, 0);
        for (int k = 0; k < TBL; k++) begin
            check("R11 R4 captured word", cap_data, exp_word(2'd2, k));
            cap_rd = 1;
            @(negedge clk);
            cap_rd = 0;
        end
        check("R11 empty after reads", cap_empty, 1);
        cap_rd = 1;
        @(negedge clk);
        cap_rd = 0;
        check("R11 read on empty ignored", cap_empty, 1);
        check("R11 read on empty not full", cap_full, 0);

        // R12 overflow
        run_seq(2'd0, 0, 0, 0);
        check("R12 overflow set", cap_overflow, 1);
        @(negedge clk);
        check("R12 overflow held", cap_overflow, 1);
        pulse_clr();
        check("R12 overflow cleared by clr", cap_overflow, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule